// File: doc/BRIEF.md
# SMBus Master SCL Clock Generator

This block produces the serial clock for a two-wire bus master. Its timebase is a set of four single-cycle timer overflow pulses. A two-bit select picks one of them, so a timer that other peripherals share can also set the bus bit rate. The low phase of SCL is held for at least one overflow period and the high phase for at least two. With no other device touching the line, one bit therefore takes three overflow periods, and the bit rate is the overflow rate divided by three.

The block never trusts its own drive alone. The sensed SCL level passes through a two-flop synchroniser. The high-phase count only begins once the line is really seen high, which lets slaves stretch the clock. If the line is pulled low by another master during the high phase, the block drops into its own low phase at once to stay in step. Two strobes tell the byte logic when SDA may change and when it should be sampled. An extended-hold option stretches the low phase so that SDA gets longer hold and setup windows around the clock edges.

When the master is not active, the same selected tick source can drive a bus-free detector. It raises a flag after SCL has stayed high for a programmable number of ticks. Byte shifting, START/STOP generation and arbitration decisions live elsewhere.

Top module: `scl_master_gen`

## Requirements
- R1: `tick_i` bit k is timer source k: bit 0 is timer 0 overflow, bit 1 is timer 1 overflow, bit 2 is timer 2 high-byte overflow and bit 3 is timer 2 low-byte overflow. `src_sel_i` equal to k selects bit k, and pulses on the other bits have no effect.
- R2: When neither `master_en_i` nor `free_en_i` is 1, tick pulses are ignored: `scl_pull_o` and `bus_free_o` stay 0. In the cycle after `master_en_i` is seen low, `scl_pull_o` is 0.
- R3: `scl_pull_o` = 1 means "drive SCL low". In steady operation with the extended hold off, each low phase lasts exactly one period P of the selected tick, provided P is at least 2 cycles.
- R4: With no stretching or contention, the time between successive rises of `scl_pull_o` is exactly 3P, and the high phase ends on the second selected tick counted after SCL is sensed high.
- R5: The high count starts only once the synchronised SCL is high. `sda_smp_o` pulses for one cycle in the first cycle of the counted high phase, 3 cycles after the sensed line goes high (two synchroniser stages plus one register).
- R6: While SCL is released but sensed low (a slave stretching the clock), `scl_pull_o` stays 0 and `sda_smp_o` stays 0, for as long as the line is held.
- R7: If the line goes low during the counted high phase while the block is not pulling it, `scl_pull_o` becomes 1 three cycles later and a fresh low phase begins.
- R8: `sda_chg_o` pulses once per low phase. It comes in the first cycle of `scl_pull_o` = 1 when `ext_hold_i` = 0, and 3 cycles later when `ext_hold_i` = 1. It never coincides with `sda_smp_o`.
- R9: A low phase lasts max(P, H+S+1) cycles. With `ext_hold_i` = 1, H = 3 and S = 4. With `ext_hold_i` = 0, H = 0 and S = 1. The setup part is the S cycles between `sda_chg_o` and the release.
- R10: With `master_en_i` = 0 and `free_en_i` = 1, `bus_free_o` becomes 1 in the cycle after the 5th selected tick counted while the synchronised SCL is high, and not before.
- R11: A low level on the line clears `bus_free_o` and its tick count. The flag is 0 three cycles after the line goes low, and still 1 two cycles after.
- R12: While `rst` is high and in the cycle after it, `scl_pull_o`, `sda_chg_o`, `sda_smp_o` and `bus_free_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 4 | Single-cycle overflow pulses, one per timer source |
| src_sel_i | input | 2 | Index of the tick source in use |
| master_en_i | input | 1 | Run the SCL generator as a master |
| free_en_i | input | 1 | Enable bus-free detection while not master |
| ext_hold_i | input | 1 | Lengthen the SDA hold and setup windows |
| scl_sense_i | input | 1 | Sensed SCL line level (asynchronous) |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_chg_o | output | 1 | One-cycle strobe: SDA may change now |
| sda_smp_o | output | 1 | One-cycle strobe: sample SDA now |
| bus_free_o | output | 1 | SCL has stayed high for the free timeout |

## Verification
The bench sweeps every source select against three tick periods, with the extended hold on and off. A wrong mux index or a gate on the wrong source would time the low phase off the fast noise pulses placed on the unused bits. A high count that ran before the line was seen high would shorten the clock whenever a slave stretches it. A block that ignored a foreign low level would keep releasing SCL instead of pulling three cycles later. Off-by-one errors in the hold, setup or free-timeout counters show up as exact cycle mismatches in the low-phase length, the strobe offset, or the tick on which the bus-free flag rises and falls.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phases of the generated clock
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // not master, line released
        PH_LOW  = 2'd1,   // pulling SCL low
        PH_WAIT = 2'd2,   // released, waiting to sense high
        PH_HIGH = 2'd3    // counting the high phase
    } scl_phase_e;

    // Strobes to the byte engine
    typedef struct packed {
        logic chg;
        logic smp;
    } sda_strobe_t;

    // Bits needed to hold the values 0..n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d_i};
    end

    assign q_o = sr[STAGES-1];
endmodule

// File: rtl/tick_mux.sv
module tick_mux #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W = scl_gen_pkg::cnt_bits(NUM_SRC - 1)
) (
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               gate_i,
    output logic               tick_o
);
    assign tick_o = gate_i & tick_i[sel_i];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int LOW_TICKS  = 1,
    parameter int HIGH_TICKS = 2,
    parameter int HOLD_EXT   = 3,
    parameter int SETUP_EXT  = 4,
    parameter int SETUP_BASE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        tick_i,
    input  logic        scl_s_i,
    input  logic        ext_hold_i,
    output logic        pull_o,
    output sda_strobe_t strobe_o,
    output scl_phase_e  phase_o
);
    localparam int TW     = cnt_bits(max2(LOW_TICKS, HIGH_TICKS));
    localparam int LC_MAX = HOLD_EXT + SETUP_EXT + SETUP_BASE;
    localparam int LCW    = cnt_bits(LC_MAX);

    scl_phase_e     phase, phase_n;
    logic [TW-1:0]  tcnt, tcnt_n;
    logic [LCW-1:0] lc, lc_n;
    logic           low_done, low_done_n;
    logic           smp_q;

    logic [LCW-1:0] hold_cyc, setup_cyc;
    logic           last_low_tick, last_high_tick;

    assign hold_cyc       = ext_hold_i ? LCW'(HOLD_EXT)  : '0;
    assign setup_cyc      = ext_hold_i ? LCW'(SETUP_EXT) : LCW'(SETUP_BASE);
    assign last_low_tick  = tick_i && !low_done && (tcnt == TW'(LOW_TICKS - 1));
    assign last_high_tick = tick_i && (tcnt == TW'(HIGH_TICKS - 1));

    always_comb begin
        phase_n    = phase;
        tcnt_n     = tcnt;
        lc_n       = lc;
        low_done_n = low_done;
        if (!en_i) begin
            phase_n = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase_n    = PH_LOW;
                    tcnt_n     = '0;
                    lc_n       = '0;
                    low_done_n = 1'b0;
                end
                PH_LOW: begin
                    if (lc != LCW'(LC_MAX)) lc_n = lc + 1'b1;
                    if (tick_i && !low_done) begin
                        if (last_low_tick) low_done_n = 1'b1;
                        else               tcnt_n     = tcnt + 1'b1;
                    end
                    if ((low_done || last_low_tick) && (lc >= hold_cyc + setup_cyc))
                        phase_n = PH_WAIT;
                end
                PH_WAIT: begin
                    if (scl_s_i) begin
                        phase_n = PH_HIGH;
                        tcnt_n  = '0;
                    end
                end
                PH_HIGH: begin
                    if (!scl_s_i || last_high_tick) begin
                        phase_n    = PH_LOW;
                        tcnt_n     = '0;
                        lc_n       = '0;
                        low_done_n = 1'b0;
                    end else if (tick_i) begin
                        tcnt_n = tcnt + 1'b1;
                    end
                end
                default: phase_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tcnt     <= '0;
            lc       <= '0;
            low_done <= 1'b0;
            smp_q    <= 1'b0;
        end else begin
            phase    <= phase_n;
            tcnt     <= tcnt_n;
            lc       <= lc_n;
            low_done <= low_done_n;
            smp_q    <= en_i && (phase == PH_WAIT) && scl_s_i;
        end
    end

    assign pull_o       = (phase == PH_LOW);
    assign strobe_o.chg = (phase == PH_LOW) && (lc == hold_cyc);
    assign strobe_o.smp = smp_q;
    assign phase_o      = phase;
endmodule

// File: rtl/bus_free_det.sv
module bus_free_det #(
    parameter int FREE_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic tick_i,
    input  logic scl_s_i,
    output logic free_o
);
    localparam int FW = scl_gen_pkg::cnt_bits(FREE_TICKS);

    logic [FW-1:0] cnt;
    logic          flag;

    always_ff @(posedge clk) begin
        if (rst || !active_i || !scl_s_i) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (tick_i && !flag) begin
            if (cnt == FW'(FREE_TICKS - 1)) flag <= 1'b1;
            else                            cnt  <= cnt + 1'b1;
        end
    end

    assign free_o = flag;
endmodule

// File: rtl/scl_master_gen.sv
module scl_master_gen
    import scl_gen_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_TICKS   = 1,
    parameter int HIGH_TICKS  = 2,
    parameter int HOLD_EXT    = 3,
    parameter int SETUP_EXT   = 4,
    parameter int SETUP_BASE  = 1,
    parameter int FREE_TICKS  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] tick_i,
    input  logic [1:0] src_sel_i,
    input  logic       master_en_i,
    input  logic       free_en_i,
    input  logic       ext_hold_i,
    input  logic       scl_sense_i,
    output logic       scl_pull_o,
    output logic       sda_chg_o,
    output logic       sda_smp_o,
    output logic       bus_free_o
);
    logic        scl_s;
    logic        tick_sel;
    sda_strobe_t strobe;
    scl_phase_e  phase;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (scl_sense_i),
        .q_o (scl_s)
    );

    tick_mux #(.NUM_SRC(NUM_SRC)) u_mux (
        .tick_i (tick_i),
        .sel_i  (src_sel_i),
        .gate_i (master_en_i | free_en_i),
        .tick_o (tick_sel)
    );

    scl_phase_fsm #(
        .LOW_TICKS  (LOW_TICKS),
        .HIGH_TICKS (HIGH_TICKS),
        .HOLD_EXT   (HOLD_EXT),
        .SETUP_EXT  (SETUP_EXT),
        .SETUP_BASE (SETUP_BASE)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en_i       (master_en_i),
        .tick_i     (tick_sel),
        .scl_s_i    (scl_s),
        .ext_hold_i (ext_hold_i),
        .pull_o     (scl_pull_o),
        .strobe_o   (strobe),
        .phase_o    (phase)
    );

    bus_free_det #(.FREE_TICKS(FREE_TICKS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .active_i (free_en_i & ~master_en_i),
        .tick_i   (tick_sel),
        .scl_s_i  (scl_s),
        .free_o   (bus_free_o)
    );

    assign sda_chg_o = strobe.chg;
    assign sda_smp_o = strobe.smp;
endmodule

// File: rtl/scl_master_gen_chk.sv
module scl_master_gen_chk
    import scl_gen_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       master_en_i,
    input logic       scl_s,
    input scl_phase_e phase,
    input logic       scl_pull_o,
    input logic       sda_chg_o,
    input logic       sda_smp_o,
    input logic       bus_free_o
);
    // R2
    master_off_release_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en_i |=> !scl_pull_o);

    // R6
    stretch_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (master_en_i && phase == PH_WAIT && !scl_s) |=> (!scl_pull_o && !sda_smp_o));

    // R7
    contention_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (master_en_i && phase == PH_HIGH && !scl_s) |=> scl_pull_o);

    // R5
    sample_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        sda_smp_o |-> (phase == PH_HIGH && !scl_pull_o));

    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(sda_chg_o && sda_smp_o));

    // R11
    free_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_s |=> !bus_free_o);

    // R12
    always @(posedge clk) begin
        if (rst) begin
            reset_quiet_chk: assert (!scl_pull_o && !sda_chg_o && !sda_smp_o && !bus_free_o);
        end
    end
endmodule

bind scl_master_gen scl_master_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .master_en_i (master_en_i),
    .scl_s       (scl_s),
    .phase       (phase),
    .scl_pull_o  (scl_pull_o),
    .sda_chg_o   (sda_chg_o),
    .sda_smp_o   (sda_smp_o),
    .bus_free_o  (bus_free_o)
);

// File: tb/scl_master_gen_test.sv
module scl_master_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd0;
    logic       master_en = 1'b0, free_en = 1'b0, ext_hold = 1'b0;
    logic       slave_low = 1'b0, other_low = 1'b0;
    logic       scl_pull, sda_chg, sda_smp, bus_free;
    logic       gen_on = 1'b0;
    logic [1:0] gen_sel = 2'd0;
    int         gen_p = 8;
    int         gcnt = 0;
    logic [3:0] gen_tick = '0, man_tick = '0;
    logic [3:0] tick;
    logic       scl_line;
    int         cyc = 0;
    int         total = 0, fails = 0;
    bit         done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign tick     = gen_on ? gen_tick : man_tick;
    assign scl_line = !scl_pull && !slave_low && !other_low;

    // Selected source pulses every gen_p cycles; the others pulse every 2 cycles
    always @(negedge clk) begin
        gcnt = (gcnt + 1 >= gen_p) ? 0 : gcnt + 1;
        for (int i = 0; i < 4; i++)
            gen_tick[i] = (i == gen_sel) ? (gcnt == 0) : cyc[0];
    end

    scl_master_gen uut (
        .clk (clk), .rst (rst), .tick_i (tick), .src_sel_i (src_sel),
        .master_en_i (master_en), .free_en_i (free_en), .ext_hold_i (ext_hold),
        .scl_sense_i (scl_line), .scl_pull_o (scl_pull), .sda_chg_o (sda_chg),
        .sda_smp_o (sda_smp), .bus_free_o (bus_free)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pull(input logic v);
        int n = 0;
        while (scl_pull !== v && n < 5000) begin step(); n++; end
    endtask

    task automatic run_cfg(input int sel, input int p, input bit ext);
        int t_r1, t_c, t_f, t_s, t_r2, n, h, s, lo;
        master_en = 0; gen_on = 1; gen_sel = 2'(sel); gen_p = p;
        src_sel = 2'(sel); ext_hold = ext;
        repeat (5) step();
        master_en = 1;
        wait_pull(1); wait_pull(0); wait_pull(1);
        t_r1 = cyc; t_c = -1; t_f = -1; t_s = -1; t_r2 = -1; n = 0;
        while (t_r2 < 0 && n < 5000) begin
            if (sda_chg && t_c < 0) t_c = cyc;
            if (!scl_pull && t_f < 0) t_f = cyc;
            if (sda_smp && t_s < 0) t_s = cyc;
            if (scl_pull && t_f >= 0) t_r2 = cyc;
            if (t_r2 < 0) step();
            n++;
        end
        h  = ext ? 3 : 0;
        s  = ext ? 4 : 1;
        lo = (p > h + s + 1) ? p : h + s + 1;
        // R1 R3 R9: low phase length from the selected source only
        check(t_f - t_r1 == lo, "R1 R3 R9 low length", t_f - t_r1, lo);
        // R8: change strobe offset
        check(t_c - t_r1 == h, "R8 chg offset", t_c - t_r1, h);
        // R9: setup between change strobe and release
        check(t_f - t_c >= s, "R9 setup window", t_f - t_c, s);
        // R5: sample strobe after release
        check(t_s - t_f == 3, "R5 smp delay", t_s - t_f, 3);
        // R4: full period
        check(t_r2 - t_r1 == 3 * p, "R4 period", t_r2 - t_r1, 3 * p);
        master_en = 0;
        step();
        // R2: release after master disable
        check(scl_pull == 0, "R2 release on disable", scl_pull, 0);
    endtask

    task automatic pulse(input int bitn);
        man_tick[bitn] = 1'b1;
        step();
        man_tick[bitn] = 1'b0;
    endtask

    initial begin
        int n, bad, d;
        repeat (3) step();
        // R12: quiet during reset
        check({scl_pull, sda_chg, sda_smp, bus_free} == 4'b0, "R12 in reset",
              {scl_pull, sda_chg, sda_smp, bus_free}, 0);
        rst = 0;
        step();
        check({scl_pull, sda_chg, sda_smp, bus_free} == 4'b0, "R12 after reset",
              {scl_pull, sda_chg, sda_smp, bus_free}, 0);

        // R2: ticks ignored with both enables low
        gen_on = 1; gen_p = 3; gen_sel = 0; src_sel = 0;
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (scl_pull || bus_free) bad++;
        end
        check(bad == 0, "R2 ticks ignored", bad, 0);

        // Sweep: all sources, three periods, hold on/off
        for (int sel = 0; sel < 4; sel++)
            for (int pi = 0; pi < 3; pi++)
                for (int e = 0; e < 2; e++)
                    run_cfg(sel, (pi == 0) ? 6 : (pi == 1) ? 8 : 12, e[0]);

        // R6 / R5: slave stretch
        gen_sel = 1; src_sel = 1; gen_p = 8; ext_hold = 0;
        repeat (3) step();
        master_en = 1;
        wait_pull(1); wait_pull(0); wait_pull(1);
        slave_low = 1;
        wait_pull(0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (scl_pull || sda_smp) bad++;
        end
        check(bad == 0, "R6 stretch hold", bad, 0);
        slave_low = 0;
        n = 0;
        while (!sda_smp && n < 100) begin step(); n++; end
        check(n == 3, "R5 smp after stretch", n, 3);
        d = 0;
        while (!scl_pull && d < 100) begin step(); d++; end
        check(d >= 9 && d <= 16, "R4 high after stretch", d, 9);

        // R7: contention during the high phase
        wait_pull(0);
        n = 0;
        while (!sda_smp && n < 100) begin step(); n++; end
        step(); step();
        other_low = 1;
        n = 0;
        while (!scl_pull && n < 100) begin step(); n++; end
        check(n == 3, "R7 contention pull", n, 3);
        other_low = 0;
        master_en = 0;
        step();

        // R10 / R11: bus-free timeout, manual ticks on source 2
        gen_on = 0; src_sel = 2; free_en = 1;
        slave_low = 1; repeat (4) step();
        slave_low = 0; repeat (4) step();
        for (int i = 0; i < 4; i++) begin pulse(2); step(); end
        check(bus_free == 0, "R10 not before 5th tick", bus_free, 0);
        pulse(3); step(); pulse(0); step();
        check(bus_free == 0, "R1 other source ignored", bus_free, 0);
        pulse(2);
        check(bus_free == 1, "R10 set on 5th tick", bus_free, 1);
        slave_low = 1;
        step(); step();
        check(bus_free == 1, "R11 still set", bus_free, 1);
        step();
        check(bus_free == 0, "R11 cleared", bus_free, 0);
        slave_low = 0;
        repeat (4) step();
        pulse(2);
        check(bus_free == 0, "R11 count restarted", bus_free, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule